// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches that software keeps servicing it. A 32-bit first stage counts down by one on every clock from a value taken from a reload register. When it reaches zero, the block raises a non-maskable interrupt request and holds it. Software can still recover at that point. If the second stage has been enabled, it starts a countdown of its own. When that countdown runs out, the block drives a system reset pulse of fixed, bounded width.

Software services the watchdog through a clear register. It must write two key words in order: first 16'hF01E, then 16'h0FE1. Only the second word copies the reload value into the counter. A lock bit freezes the reload value and the second-stage enable until the next hardware reset. All registers are 16 bits wide. The 32-bit quantities are split into a low word and a high word.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, `nmi_req` and `sys_rst` are low. The reload value equals parameter RELOAD_INIT. Control (address 5) reads 0 and status (address 6) reads 0.
- R2: The counter falls by one each clock. A read of address 2 returns the counter's low word and captures its high word at that moment. A later read of address 3 returns that captured word.
- R3: When the counter reaches zero, status bit 0 (expired) and `nmi_req` go high. A service with reload R makes `nmi_req` rise R+1 clocks after the clock edge that accepts the second key.
- R4: Two writes to address 4, first 16'hF01E and then 16'h0FE1, load the reload value (low word at address 0, high word at address 1) into the counter. They also clear expired and `nmi_req`.
- R5: Any write to address 4 that is not the next expected key word aborts the sequence and clears the pending half. This covers a second 16'hF01E. It also covers 16'h0FE1 written with no 16'hF01E before it. An aborted sequence loads nothing.
- R6: Control bit 0 enables the second stage. While it is 0, expiry only holds `nmi_req` and never produces `sys_rst`.
- R7: While control bit 0 is 1, `sys_rst` rises S2_CYCLES+1 clocks after expiry. It then stays high for exactly CLK_HZ/1000*RST_MS clocks.
- R8: A completed service while the second stage is counting cancels the pending reset.
- R9: Writing control bit 1 as 1 sets a lock that only reset clears. While locked, writes to the reload words and to control are ignored. Reads still return the held values.
- R10: When the reset pulse ends, the counter reloads from the reload value and expired clears, so the first stage starts a new period.
- R11: The status word has four bits: bit 0 expired, bit 1 second stage counting, bit 2 reset pulse active, and bit 3 first key accepted and second key pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for count capture) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from address) |
| nmi_req | output | 1 | First-stage expiry interrupt request |
| sys_rst | output | 1 | Second-stage system reset pulse |

## Verification
The bench builds the block with CLK_HZ=10000, RST_MS=400, S2_CYCLES=30 and RELOAD_INIT=64. With these values the reset pulse lasts 4000 clocks, so its full width can be measured edge to edge. The second-stage delay is short enough to cancel it part-way through. A small reload value brings first-stage expiry within a few dozen clocks. A reload of 0x0001_0002 makes the count borrow across the 16-bit word boundary, which exercises the captured high word.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    A_RLD_LO = 3'd0,
    A_RLD_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_CLEAR  = 3'd4,
    A_CTRL   = 3'd5,
    A_STAT   = 3'd6
  } wdt_addr_e;

  localparam logic [15:0] KEY_FIRST  = 16'hF01E;
  localparam logic [15:0] KEY_SECOND = 16'h0FE1;

  typedef enum logic {K_IDLE = 1'b0, K_HALF = 1'b1} key_state_e;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             svc,
  output logic             half
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    svc  = 1'b0;
    if (clr_wr) begin
      if (st_q == K_IDLE && wdata == REG_W'(KEY_FIRST)) begin
        st_d = K_HALF;
      end else if (st_q == K_HALF && wdata == REG_W'(KEY_SECOND)) begin
        st_d = K_IDLE;
        svc  = 1'b1;
      end else begin
        st_d = K_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_IDLE;
    else        st_q <= st_d;
  end

  assign half = (st_q == K_HALF);

  // R5: a wrong word while half-entered returns to idle without service
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && half && wdata != REG_W'(KEY_SECOND)) |=> !half && !$past(svc));
endmodule

// File: rtl/wdt_stage1.sv
module wdt_stage1 #(
  parameter int          CNT_W       = 32,
  parameter int unsigned RELOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expired,
  output logic             expire_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;

  always_comb begin
    cnt_d      = cnt_q;
    exp_d      = exp_q;
    expire_evt = 1'b0;
    if (load) begin
      cnt_d = reload;
      exp_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (!exp_q) begin
      exp_d      = 1'b1;
      expire_evt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RELOAD_INIT);
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt     = cnt_q;
  assign expired = exp_q;

  // R3: expiry only follows a zero count
  a_r3_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_q) |-> $past(cnt_q) == '0);
  // R4: a load copies the reload value and clears expiry
  a_r4_load_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)) && !exp_q);
endmodule

// File: rtl/wdt_stage2.sv
module wdt_stage2 #(
  parameter int S2_CYCLES  = 1000000,
  parameter int RST_CYCLES = 10000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic cancel,
  output logic running,
  output logic rst_out,
  output logic done
);
  localparam int S2_W = $clog2(S2_CYCLES + 1);
  localparam int R_W  = $clog2(RST_CYCLES);

  logic            run_q, run_d;
  logic [S2_W-1:0] s2_q, s2_d;
  logic            rst_q, rst_d;
  logic [R_W-1:0]  rc_q, rc_d;

  always_comb begin
    run_d = run_q;
    s2_d  = s2_q;
    rst_d = rst_q;
    rc_d  = rc_q;
    done  = 1'b0;
    if (rst_q) begin
      if (rc_q == '0) begin
        rst_d = 1'b0;
        done  = 1'b1;
      end else begin
        rc_d = rc_q - 1'b1;
      end
    end else if (cancel) begin
      run_d = 1'b0;
    end else if (run_q) begin
      if (s2_q == '0) begin
        run_d = 1'b0;
        rst_d = 1'b1;
        rc_d  = R_W'(RST_CYCLES - 1);
      end else begin
        s2_d = s2_q - 1'b1;
      end
    end else if (start && en) begin
      run_d = 1'b1;
      s2_d  = S2_W'(S2_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      s2_q  <= '0;
      rst_q <= 1'b0;
      rc_q  <= '0;
    end else begin
      run_q <= run_d;
      s2_q  <= s2_d;
      rst_q <= rst_d;
      rc_q  <= rc_d;
    end
  end

  assign running = run_q;
  assign rst_out = rst_q;

  // checker counter: cycles the pulse has already been high
  logic [R_W:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (rst_q) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  // R7: pulse never exceeds its width and only follows the second stage
  a_r7_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> hi_len < (R_W+1)'(RST_CYCLES));
  a_r7_rst_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(run_q));
  // R6: the second stage starts only when enabled
  a_r6_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(en));
  // R8: a service stops the countdown
  a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !rst_q) |=> !run_q && !rst_q);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int          REG_W       = 16,
  parameter int          CLK_HZ      = 25000000,
  parameter int          RST_MS      = 400,
  parameter int          S2_CYCLES   = 1000000,
  parameter int unsigned RELOAD_INIT = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             nmi_req,
  output logic             sys_rst
);
  localparam int CNT_W      = 2 * REG_W;
  localparam int NHALF      = CNT_W / REG_W;
  localparam int RST_CYCLES = (CLK_HZ / 1000) * RST_MS;

  wdt_addr_e addr;
  assign addr = wdt_addr_e'(reg_addr);

  logic             s2en_q, s2en_d, lock_q, lock_d;
  logic [REG_W-1:0] snap_q, snap_d;
  logic [CNT_W-1:0] reload, cnt;
  logic             expired, expire_evt, svc, svc_ok, half;
  logic             running, rst_act, done, load;

  // reload words, one register per half
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [REG_W-1:0] q, d;
    always_comb begin
      d = q;
      if (reg_wr && !lock_q && reg_addr == 3'(int'(A_RLD_LO) + h)) d = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= REG_W'(CNT_W'(RELOAD_INIT) >> (h * REG_W));
      else        q <= d;
    end
    assign reload[h*REG_W +: REG_W] = q;
  end

  // control, lock and count capture
  always_comb begin
    s2en_d = s2en_q;
    lock_d = lock_q;
    snap_d = snap_q;
    if (reg_wr && addr == A_CTRL && !lock_q) begin
      s2en_d = reg_wdata[0];
      lock_d = reg_wdata[1];
    end
    if (reg_rd && addr == A_CNT_LO) snap_d = cnt[CNT_W-1:REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2en_q <= 1'b0;
      lock_q <= 1'b0;
      snap_q <= '0;
    end else begin
      s2en_q <= s2en_d;
      lock_q <= lock_d;
      snap_q <= snap_d;
    end
  end

  wdt_keyseq #(.REG_W(REG_W)) u_key (
    .clk(clk), .rst_n(rst_n),
    .clr_wr(reg_wr && addr == A_CLEAR),
    .wdata(reg_wdata), .svc(svc), .half(half)
  );

  assign svc_ok = svc && !rst_act;
  assign load   = svc_ok || done;

  wdt_stage1 #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_s1 (
    .clk(clk), .rst_n(rst_n), .load(load), .reload(reload),
    .cnt(cnt), .expired(expired), .expire_evt(expire_evt)
  );

  wdt_stage2 #(.S2_CYCLES(S2_CYCLES), .RST_CYCLES(RST_CYCLES)) u_s2 (
    .clk(clk), .rst_n(rst_n), .en(s2en_q), .start(expire_evt),
    .cancel(svc_ok), .running(running), .rst_out(rst_act), .done(done)
  );

  always_comb begin
    case (addr)
      A_RLD_LO: reg_rdata = reload[REG_W-1:0];
      A_RLD_HI: reg_rdata = reload[CNT_W-1:REG_W];
      A_CNT_LO: reg_rdata = cnt[REG_W-1:0];
      A_CNT_HI: reg_rdata = snap_q;
      A_CTRL:   reg_rdata = {{(REG_W-2){1'b0}}, lock_q, s2en_q};
      A_STAT:   reg_rdata = {{(REG_W-4){1'b0}}, half, rst_act, running, expired};
      default:  reg_rdata = '0;
    endcase
  end

  assign nmi_req = expired;
  assign sys_rst = rst_act;

  // R9: lock is sticky and freezes the reload value
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r9_reload_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(reload));
  // R10: end of pulse restarts the first stage
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !nmi_req && cnt == reload);
endmodule

// File: tb/wdt_two_stage_test.sv
`timescale 1ns/1ps
module wdt_two_stage_test;
  localparam int RSTW = 4000;
  localparam int S2   = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        nmi_req, sys_rst;

  wdt_two_stage #(.REG_W(16), .CLK_HZ(10000), .RST_MS(400), .S2_CYCLES(S2),
                  .RELOAD_INIT(32'd64)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .sys_rst(sys_rst)
  );

  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  int rst_rises = 0;

  typedef struct { string tag; logic [15:0] exp; } item_t;
  item_t sbq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as reads occur
  always @(negedge clk) begin
    #1;
    if (reg_rd) begin
      if (sbq.size() == 0) chk("scoreboard empty", 1, 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, {16'h0, reg_rdata}, {16'h0, it.exp});
      end
    end
  end

  always @(posedge sys_rst) rst_rises++;

  task automatic wr(logic [2:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    item_t it;
    it.tag = tag; it.exp = e;
    sbq.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic service();
    wr(3'd4, 16'hF01E);
    wr(3'd4, 16'h0FE1);
  endtask

  task automatic wait_nmi(output int k);
    k = 0;
    while (!nmi_req && k < 20000) begin @(negedge clk); k++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int k, w;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 nmi", nmi_req, 0);
    chk("R1 sys_rst", sys_rst, 0);
    rd(3'd0, 16'h0040, "R1 reload lo");
    rd(3'd1, 16'h0000, "R1 reload hi");
    rd(3'd5, 16'h0000, "R1 control");
    rd(3'd6, 16'h0000, "R1 status");

    // R3/R4 first stage period
    wr(3'd0, 16'd20);
    wr(3'd1, 16'd0);
    service();
    chk("R4 nmi clear", nmi_req, 0);
    wait_nmi(k);
    chk("R3 expiry delay", k, 21);
    rd(3'd6, 16'h0001, "R11 status expired");
    // R6 no reset while stage two disabled
    repeat (100) @(negedge clk);
    chk("R6 no reset", rst_rises, 0);
    chk("R6 nmi held", nmi_req, 1);

    // R5 key aborts
    wr(3'd4, 16'h0FE1);
    chk("R5 lone second key", nmi_req, 1);
    wr(3'd4, 16'hF01E);
    rd(3'd6, 16'h0009, "R11 key half");
    wr(3'd4, 16'hF01E);
    rd(3'd6, 16'h0001, "R5 repeat first key aborts");
    wr(3'd4, 16'hF01E);
    wr(3'd4, 16'h1234);
    wr(3'd4, 16'h0FE1);
    chk("R5 wrong word aborts", nmi_req, 1);
    service();
    chk("R4 service clears nmi", nmi_req, 0);

    // R2 snapshot across word boundary
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0002);
    service();
    rd(3'd2, 16'h0002, "R2 count lo");
    rd(3'd3, 16'h0001, "R2 count hi captured");
    repeat (3) @(negedge clk);
    rd(3'd2, 16'hFFFD, "R2 count lo after borrow");
    rd(3'd3, 16'h0000, "R2 count hi after borrow");

    // R7 second stage reset
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd20);
    wr(3'd5, 16'h0001);
    rd(3'd5, 16'h0001, "R6 control enable");
    service();
    wait_nmi(k);
    chk("R3 expiry delay again", k, 21);
    k = 0;
    while (!sys_rst && k < 1000) begin @(negedge clk); k++; end
    chk("R7 reset delay", k, S2 + 1);
    rd(3'd6, 16'h0005, "R11 status reset active");
    w = 1;
    while (sys_rst && w < 10000) begin @(negedge clk); w++; end
    chk("R7 reset width", w, RSTW);
    chk("R10 nmi cleared", nmi_req, 0);
    wait_nmi(k);
    chk("R10 new period", k, 21);

    // R8 cancel during stage two
    repeat (10) @(negedge clk);
    rd(3'd6, 16'h0003, "R11 stage two running");
    service();
    repeat (40) @(negedge clk);
    chk("R8 reset cancelled", rst_rises, 1);
    chk("R8 sys_rst low", sys_rst, 0);

    // R9 lockout
    wr(3'd5, 16'h0003);
    rd(3'd5, 16'h0003, "R9 lock set");
    wr(3'd0, 16'h0055);
    rd(3'd0, 16'h0014, "R9 reload frozen");
    wr(3'd5, 16'h0000);
    rd(3'd5, 16'h0003, "R9 lock sticky");

    @(negedge clk);
    summary();
    $finish;
  end
endmodule